// File: doc/BRIEF.md
# Hamming SEC-DED Codec

This block protects a fixed-width data word with an extended Hamming code. The encoder side takes a data word and builds a codeword. Each check bit sits at a power-of-two position, the data bits fill the other positions, and codeword bit 0 carries an overall parity bit that adds double-error detection. The decoder side takes a possibly damaged codeword and recomputes the parity groups to form a syndrome. It repairs any single flipped bit, then presents the data together with an outcome code and the syndrome.

The code size comes from one parameter `M`, the number of Hamming check bits. The default `M = 4` gives 11 data bits and a 16-bit extended codeword: 15 Hamming positions plus the parity bit. Decoder results are registered, so they appear one clock after the codeword is presented. The encoder output is registered by default, and a parameter can make it combinational instead.

Top module: `hamming_secded`

## Requirements
- R1: With parameter M the codeword has N = 2^M - 1 Hamming positions plus bit 0, and the data word has K = 2^M - M - 1 bits. The default M = 4 gives a 16-bit codeword and 11 data bits.
- R2: Codeword bit index equals position. Check bit i sits at bit 2^i. Data bit 0 goes to the lowest position that is not a power of two, and the others follow in ascending order (positions 3, 5, 6, 7, 9, ... for the default).
- R3: Check bit i is chosen so that the XOR of every position whose index has bit i set (bit i of the index is 1) is zero.
- R4: Codeword bit 0 makes the XOR of all codeword bits zero (even overall parity).
- R5: With the default registered encoder, `enc_code_o` and `enc_valid_o` follow `enc_data_i` and `enc_valid_i` one clock later.
- R6: `dec_valid_o` is `dec_valid_i` delayed by one clock.
- R7: An undamaged codeword decodes to status 00 (clean), syndrome 0 and the original data.
- R8: A single flipped bit at position p in 1..N decodes to status 01 (corrected), syndrome p and the original data.
- R9: A flip of bit 0 alone decodes to status 01, syndrome 0 and the original data.
- R10: Two flipped bits decode to status 10 (uncorrectable). The syndrome is the XOR of the two positions, with bit 0 counting as position 0, and the data is taken unrepaired from the received word.
- R11: While reset is active, both valid outputs are 0 and the decoder data, status and syndrome registers are 0.
- R12: When `dec_valid_i` is 0, the decoder data, status and syndrome outputs keep their last values, whatever `dec_code_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | K | Data word to encode |
| enc_valid_o | output | 1 | Encoder output qualifier |
| enc_code_o | output | N+1 | Codeword, bit 0 = overall parity |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_code_i | input | N+1 | Received codeword |
| dec_valid_o | output | 1 | Decoder output qualifier |
| dec_data_o | output | K | Decoded data |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| dec_syndrome_o | output | M | Syndrome of the received word |

## Verification
The assertions check on every cycle that the decoder valid tracks its input with one clock of delay. They also check that every encoder codeword has even overall parity, that odd received parity always gives the corrected status and even received parity never does, and that the clean and uncorrectable statuses agree with the reported syndrome. Only the bench scenarios can show the exact bit placement, the syndrome value for each flipped position, that the repaired data is correct, and that the outputs hold while valid is low. The bench covers these with a sweep over every single-bit position, chosen double errors and random words.

// File: rtl/hc_pkg.sv
package hc_pkg;

   typedef enum logic [1:0] {
      HC_CLEAN  = 2'b00,
      HC_FIXED  = 2'b01,
      HC_UNCORR = 2'b10
   } hc_status_e;

   // floor(log2(v)) for v >= 1
   function automatic int hc_flog2(input int v);
      int r;
      r = 0;
      for (int b = 0; b < 31; b++) begin
         if ((v >> b) != 0) r = b;
      end
      return r;
   endfunction

   // power-of-two positions carry check bits
   function automatic bit hc_is_check(input int p);
      return (p & (p - 1)) == 0;
   endfunction

   // data index held at a non-power-of-two position p
   function automatic int hc_data_idx(input int p);
      return p - hc_flog2(p) - 2;
   endfunction

endpackage

// File: rtl/hc_encoder.sv
module hc_encoder #(
   parameter int M = 4,
   parameter int N = (1 << M) - 1,
   parameter int K = N - M
) (
   input  logic [K-1:0] data_i,
   output logic [N:0]   code_o
);
   import hc_pkg::*;

   function automatic logic [N:0] cover_mask(input int i);
      logic [N:0] msk;
      msk = '0;
      for (int p = 1; p <= N; p++) begin
         if (((p >> i) & 1) != 0) msk[p] = 1'b1;
      end
      return msk;
   endfunction

   logic [N:0] placed;
   logic [N:1] body;

   assign placed[0] = 1'b0;

   for (genvar p = 1; p <= N; p++) begin : g_place
      if (hc_is_check(p)) begin : g_chk_slot
         assign placed[p] = 1'b0;
      end else begin : g_dat_slot
         assign placed[p] = data_i[hc_data_idx(p)];
         assign body[p]   = data_i[hc_data_idx(p)];
      end
   end

   for (genvar i = 0; i < M; i++) begin : g_check
      localparam logic [N:0] COVER = cover_mask(i);
      assign body[1 << i] = ^(placed & COVER);
   end

   assign code_o = {body, ^body};

endmodule

// File: rtl/hc_syndrome.sv
module hc_syndrome #(
   parameter int M = 4,
   parameter int N = (1 << M) - 1
) (
   input  logic [N:0]   code_i,
   output logic [M-1:0] syn_o,
   output logic         perr_o
);

   function automatic logic [N:0] cover_mask(input int i);
      logic [N:0] msk;
      msk = '0;
      for (int p = 1; p <= N; p++) begin
         if (((p >> i) & 1) != 0) msk[p] = 1'b1;
      end
      return msk;
   endfunction

   for (genvar i = 0; i < M; i++) begin : g_syn
      localparam logic [N:0] COVER = cover_mask(i);
      assign syn_o[i] = ^(code_i & COVER);
   end

   assign perr_o = ^code_i;

endmodule

// File: rtl/hc_corrector.sv
module hc_corrector #(
   parameter int M = 4,
   parameter int N = (1 << M) - 1,
   parameter int K = N - M
) (
   input  logic [N:0]        code_i,
   input  logic [M-1:0]      syn_i,
   input  logic              perr_i,
   output logic [K-1:0]      data_o,
   output hc_pkg::hc_status_e status_o
);
   import hc_pkg::*;

   localparam logic [N:0] ONE = {{N{1'b0}}, 1'b1};

   logic [N:0] flip;
   logic [N:0] fixed;

   assign flip  = perr_i ? (ONE << syn_i) : '0;
   assign fixed = code_i ^ flip;

   for (genvar p = 1; p <= N; p++) begin : g_pull
      if (!hc_is_check(p)) begin : g_dat
         assign data_o[hc_data_idx(p)] = fixed[p];
      end
   end

   always_comb begin
      if (perr_i)            status_o = HC_FIXED;
      else if (syn_i != '0)  status_o = HC_UNCORR;
      else                   status_o = HC_CLEAN;
   end

endmodule

// File: rtl/hamming_secded.sv
module hamming_secded #(
   parameter int M       = 4,
   parameter bit REG_ENC = 1'b1,
   localparam int N      = (1 << M) - 1,
   localparam int K      = N - M
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enc_valid_i,
   input  logic [K-1:0] enc_data_i,
   output logic         enc_valid_o,
   output logic [N:0]   enc_code_o,
   input  logic         dec_valid_i,
   input  logic [N:0]   dec_code_i,
   output logic         dec_valid_o,
   output logic [K-1:0] dec_data_o,
   output logic [1:0]   dec_status_o,
   output logic [M-1:0] dec_syndrome_o
);
   import hc_pkg::*;

   if (M < 3 || M > 8) begin : g_bad_m
      $error("hamming_secded: M must lie in 3..8");
   end

   // ---------------- encoder ----------------
   logic [N:0] enc_comb;

   hc_encoder #(.M(M), .N(N), .K(K)) u_enc (
      .data_i (enc_data_i),
      .code_o (enc_comb)
   );

   if (REG_ENC) begin : g_enc_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            enc_valid_o <= 1'b0;
            enc_code_o  <= '0;
         end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) enc_code_o <= enc_comb;
         end
      end
   end else begin : g_enc_comb
      assign enc_valid_o = enc_valid_i;
      assign enc_code_o  = enc_comb;
   end

   // ---------------- decoder ----------------
   logic [M-1:0] syn;
   logic         perr;
   logic [K-1:0] dat_fix;
   hc_status_e   sts;

   hc_syndrome #(.M(M), .N(N)) u_syn (
      .code_i (dec_code_i),
      .syn_o  (syn),
      .perr_o (perr)
   );

   hc_corrector #(.M(M), .N(N), .K(K)) u_fix (
      .code_i   (dec_code_i),
      .syn_i    (syn),
      .perr_i   (perr),
      .data_o   (dat_fix),
      .status_o (sts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid_o    <= 1'b0;
         dec_data_o     <= '0;
         dec_status_o   <= 2'b00;
         dec_syndrome_o <= '0;
      end else begin
         dec_valid_o <= dec_valid_i;
         if (dec_valid_i) begin
            dec_data_o     <= dat_fix;
            dec_status_o   <= sts;
            dec_syndrome_o <= syn;
         end
      end
   end

endmodule

// File: rtl/hamming_secded_chk.sv
module hamming_secded_chk #(
   parameter int M = 4,
   parameter int N = (1 << M) - 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         enc_valid_o,
   input logic [N:0]   enc_code_o,
   input logic         dec_valid_i,
   input logic [N:0]   dec_code_i,
   input logic         dec_valid_o,
   input logic [1:0]   dec_status_o,
   input logic [M-1:0] dec_syndrome_o
);

   // R6
   dec_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_i |=> dec_valid_o);

   // R6
   dec_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> !dec_valid_o);

   // R4
   enc_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid_o |-> (^enc_code_o) == 1'b0);

   // R8
   odd_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_i && (^dec_code_i)) |=> dec_status_o == 2'b01);

   // R10
   even_not_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_i && !(^dec_code_i)) |=> dec_status_o != 2'b01);

   // R7
   clean_zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_status_o == 2'b00) |-> dec_syndrome_o == '0);

   // R10
   uncorr_nonzero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_status_o == 2'b10) |-> dec_syndrome_o != '0);

endmodule

bind hamming_secded hamming_secded_chk #(.M(M), .N(N)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enc_valid_o    (enc_valid_o),
   .enc_code_o     (enc_code_o),
   .dec_valid_i    (dec_valid_i),
   .dec_code_i     (dec_code_i),
   .dec_valid_o    (dec_valid_o),
   .dec_status_o   (dec_status_o),
   .dec_syndrome_o (dec_syndrome_o)
);

// File: tb/hamming_secded_test.sv
module hamming_secded_test;

   localparam int M        = 4;
   localparam int N        = 15;
   localparam int K        = 11;
   localparam int CLK_PER  = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         enc_valid_i;
   logic [K-1:0] enc_data_i;
   logic         enc_valid_o;
   logic [N:0]   enc_code_o;
   logic         dec_valid_i;
   logic [N:0]   dec_code_i;
   logic         dec_valid_o;
   logic [K-1:0] dec_data_o;
   logic [1:0]   dec_status_o;
   logic [M-1:0] dec_syndrome_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   hamming_secded #(.M(M)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .enc_valid_i    (enc_valid_i),
      .enc_data_i     (enc_data_i),
      .enc_valid_o    (enc_valid_o),
      .enc_code_o     (enc_code_o),
      .dec_valid_i    (dec_valid_i),
      .dec_code_i     (dec_code_i),
      .dec_valid_o    (dec_valid_o),
      .dec_data_o     (dec_data_o),
      .dec_status_o   (dec_status_o),
      .dec_syndrome_o (dec_syndrome_o)
   );

   // reference encoder built from R2, R3, R4
   function automatic logic [N:0] ref_enc(input logic [K-1:0] d);
      logic [N:0] c;
      int j;
      c = '0;
      j = 0;
      for (int p = 1; p <= N; p++) begin
         if ((p & (p - 1)) != 0) begin
            c[p] = d[j];
            j++;
         end
      end
      for (int i = 0; i < M; i++) begin
         logic x;
         x = 1'b0;
         for (int p = 1; p <= N; p++) begin
            if (((p >> i) & 1) != 0 && p != (1 << i)) x = x ^ c[p];
         end
         c[1 << i] = x;
      end
      c[0] = ^c[N:1];
      return c;
   endfunction

   function automatic logic [K-1:0] ref_ext(input logic [N:0] c);
      logic [K-1:0] d;
      int j;
      d = '0;
      j = 0;
      for (int p = 1; p <= N; p++) begin
         if ((p & (p - 1)) != 0) begin
            d[j] = c[p];
            j++;
         end
      end
      return d;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // present data to the encoder and a damaged copy to the decoder
   task automatic step(input logic [K-1:0] d, input logic [N:0] flips);
      logic [N:0]   code;
      logic [N:0]   rx;
      logic [M-1:0] esyn;
      int           nf;
      code = ref_enc(d);
      rx   = code ^ flips;
      nf   = $countones(flips);
      esyn = '0;
      for (int p = 1; p <= N; p++) begin
         if (flips[p]) esyn = esyn ^ M'(p);
      end
      @(negedge clk);
      enc_valid_i = 1'b1;
      enc_data_i  = d;
      dec_valid_i = 1'b1;
      dec_code_i  = rx;
      @(negedge clk);
      enc_valid_i = 1'b0;
      dec_valid_i = 1'b0;
      chk("R5", "enc valid", 32'(enc_valid_o), 32'd1);
      chk("R2 R3 R4", "enc code", 32'(enc_code_o), 32'(code));
      chk("R6", "dec valid", 32'(dec_valid_o), 32'd1);
      if (nf == 0) begin
         chk("R7", "status", 32'(dec_status_o), 32'd0);
         chk("R7", "syndrome", 32'(dec_syndrome_o), 32'd0);
         chk("R7", "data", 32'(dec_data_o), 32'(d));
      end else if (nf == 1 && !flips[0]) begin
         chk("R8", "status", 32'(dec_status_o), 32'd1);
         chk("R8", "syndrome", 32'(dec_syndrome_o), 32'(esyn));
         chk("R8", "data", 32'(dec_data_o), 32'(d));
      end else if (nf == 1) begin
         chk("R9", "status", 32'(dec_status_o), 32'd1);
         chk("R9", "syndrome", 32'(dec_syndrome_o), 32'd0);
         chk("R9", "data", 32'(dec_data_o), 32'(d));
      end else begin
         chk("R10", "status", 32'(dec_status_o), 32'd2);
         chk("R10", "syndrome", 32'(dec_syndrome_o), 32'(esyn));
         chk("R10", "data", 32'(dec_data_o), 32'(ref_ext(rx)));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [K-1:0] keep_d;
      logic [1:0]   keep_s;
      logic [M-1:0] keep_y;
      void'($urandom(32'h5EC0DE));
      rst_n       = 1'b0;
      enc_valid_i = 1'b0;
      enc_data_i  = '0;
      dec_valid_i = 1'b0;
      dec_code_i  = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "enc valid", 32'(enc_valid_o), 32'd0);
      chk("R11", "dec valid", 32'(dec_valid_o), 32'd0);
      chk("R11", "dec data", 32'(dec_data_o), 32'd0);
      chk("R11", "dec status", 32'(dec_status_o), 32'd0);
      chk("R11", "dec syndrome", 32'(dec_syndrome_o), 32'd0);
      rst_n = 1'b1;

      // R1 sizes of the default code
      chk("R1", "code width", 32'($bits(enc_code_o)), 32'd16);
      chk("R1", "data width", 32'($bits(dec_data_o)), 32'd11);

      // R2 placement: single data bit 0 lands at position 3, covers checks 1 and 2
      step(11'h001, '0);
      chk("R2", "pos3 layout", 32'(enc_code_o), 32'h000F);

      step('0, '0);
      step('1, '0);
      // R8 / R9 every single position
      for (int p = 0; p <= N; p++) begin
         step(11'h5A3, 16'(1) << p);
      end
      // R10 chosen double errors
      step(11'h2C1, 16'h0006);
      step(11'h2C1, 16'h0021);
      step(11'h7FF, 16'hC000);
      step(11'h000, 16'h8001);

      // R12 hold while valid low
      step(11'h3A5, 16'h0200);
      keep_d = dec_data_o;
      keep_s = dec_status_o;
      keep_y = dec_syndrome_o;
      dec_code_i = 16'hFFF0;
      @(negedge clk);
      chk("R12", "valid low", 32'(dec_valid_o), 32'd0);
      chk("R12", "data held", 32'(dec_data_o), 32'(keep_d));
      chk("R12", "status held", 32'(dec_status_o), 32'(keep_s));
      chk("R12", "syndrome held", 32'(dec_syndrome_o), 32'(keep_y));
      chk("R5", "enc valid low", 32'(enc_valid_o), 32'd0);

      // random mix of error classes
      for (int it = 0; it < 300; it++) begin
         logic [K-1:0] d;
         logic [N:0]   fl;
         int           a;
         int           b;
         int           kind;
         d    = K'($urandom);
         kind = int'($urandom % 3);
         a    = int'($urandom % (N + 1));
         b    = (a + 1 + int'($urandom % N)) % (N + 1);
         fl   = '0;
         if (kind >= 1) fl[a] = 1'b1;
         if (kind == 2) fl[b] = 1'b1;
         step(d, fl);
      end

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule